// File: doc/BRIEF.md
# Timer-Shared Port Pin Controller

This block manages an eight-pin parallel port where every pin is also shared with a timer. Most pins have a fixed direction. Pins 6 to 4 always drive, and pins 2 to 0 are always inputs. Only pins 7 and 3 have a programmable direction bit. The block holds the port's output latch and the two direction bits, and it chooses, per pin, whether the port latch or a timer function owns the pad. It also returns a per-pin read value and routes pin levels to the capture and pulse-accumulator inputs of the timer.

The timer counters, capture registers and compare logic sit elsewhere. Their compare levels and per-pin enable flags arrive as inputs. Register writes use a synchronous strobe. Register reads are combinational, so `rd_data` follows `rd_addr` and the pins in the same cycle.

A timer function that owns a pin blocks port writes from reaching that pin. The latch still takes the written value, and the value appears on the pin once the timer function releases it.

Top module: `pa_timer_port`

## Requirements
- R1: After reset, the latch holds zero and both direction bits read 0. With all timer enables low, `pin_oe` is 8'h70, `pin_out` is 8'h00, and a direction read returns 8'h00.
- R2: Register addresses:
  - `wr_addr`/`rd_addr` value 0 selects the data latch, and value 1 selects direction.
  - In a direction write, bit 7 sets pin 7's direction and bit 3 sets pin 3's direction (1 = output). A direction read returns those two bits in the same positions, with zeros in all other bits.
  - Addresses 2 and 3 read as 8'h00, and writes to them change nothing.
- R3: Pins 6:4 always have `pin_oe` high. Pins 2:0 always have `pin_oe` low and `pin_out` low.
- R4: Pins 7 and 3, when no timer function owns them:
  - they drive (`pin_oe` high) exactly when their direction bit is 1;
  - `pin_out` carries the latch bit whether or not the pin is enabled.
- R5: A read of address 0 returns, per bit, `pin_out` for a pin whose `pin_oe` is high and `pin_in` for a pin whose `pin_oe` is low.
- R6: A data write loads all eight latch bits on the clock edge. From the next cycle, the new value appears on every pin that is driven from the latch. A pin that a timer owns keeps its timer level, and shows the latch value once the timer releases it.
- R7: Compare 1 has the highest priority. When `oc1_en[k]` is high, pin k+3 drives `oc1_lvl[k]` with `pin_oe` high, whatever the other enables and the direction bit say (k = 0..4).
- R8: Other compare outputs:
  - When `oc1_en[k]` is low and `ocx_en[k]` is high, pin k+3 drives `ocx_lvl[k]` (k = 1..3, pins 4..6).
  - For k = 0 (pin 3), this applies only while `ch4_cap` is 0.
- R9: With `ch4_cap` = 1, pin 3 works as a capture channel:
  - `ic4_en` high makes pin 3 an input (`pin_oe` low) regardless of its direction bit, unless compare 1 owns it;
  - `ocx_en[0]` has no effect.
  - With `ch4_cap` = 0, `ic4_en` has no effect.
- R10: Capture taps:
  - `cap_tap[2:0]` equals `pin_in[2:0]`.
  - `cap_tap[3]` equals `oc1_lvl[0]` when `ic4_from_oc1` is 1, and `pin_in[3]` otherwise.
- R11: `pacc_tap` always equals `pin_in[7]`, whether pin 7 is an input, a port output or a compare output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 data, 1 direction) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (0 data, 1 direction) |
| rd_data | output | 8 | Combinational read data |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad drive levels |
| pin_oe | output | 8 | Pad output enables |
| oc1_en | input | 5 | Compare 1 owns pin k+3 |
| oc1_lvl | input | 5 | Compare 1 level for pin k+3 |
| ocx_en | input | 4 | Compare 5,4,3,2 enable for pin k+3 |
| ocx_lvl | input | 4 | Compare level for pin k+3 |
| ch4_cap | input | 1 | Pin 3 shared channel: 1 capture, 0 compare |
| ic4_en | input | 1 | Capture enable on pin 3 |
| ic4_from_oc1 | input | 1 | Feed capture 4 from compare 1 level instead of pin 3 |
| cap_tap | output | 4 | Capture inputs for pins 3..0 |
| pacc_tap | output | 1 | Pulse-accumulator input |

## Verification
The assertions assume that the timer side holds `oc1_en`, `ocx_en`, `ch4_cap` and `ic4_en` steady within a cycle, and that the pad levels reach `pin_in` without combinational loopback from `pin_out`. The bench drives every input only at the falling edge and chooses pad levels independently of the drive values, so both assumptions hold. Timer enables are kept off during one long phase so that the port-latch paths are exercised, and they are made dense in another phase so that the priority paths are exercised. Directed cycles cover writes made while a timer owns a pin, followed by the timer releasing the pin.

// File: rtl/pa_pkg.sv
package pa_pkg;

    localparam int PORT_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int SHARED_LO = 3;                    // lowest timer-drivable pin
    localparam int OC1_W     = PORT_W - SHARED_LO;   // pins SHARED_LO..PORT_W-1
    localparam int OCX_W     = OC1_W - 1;            // pins SHARED_LO..PORT_W-2
    localparam int CAP_W     = SHARED_LO + 1;        // pins 0..SHARED_LO
    localparam int PIN_CH4   = SHARED_LO;
    localparam int PIN_PACC  = PORT_W - 1;
    localparam int DIR_W     = 2;

    localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_DIR  = ADDR_W'(1);

    typedef enum logic [1:0] {
        PK_IN_CAP  = 2'd0,
        PK_OUT_CMP = 2'd1,
        PK_IO_CH4  = 2'd2,
        PK_IO_PACC = 2'd3
    } pin_kind_e;

    typedef struct packed {
        logic oe;
        logic lvl;
    } drive_t;

    typedef struct packed {
        logic oc1_on;
        logic oc1_lvl;
        logic ocx_on;
        logic ocx_lvl;
        logic ic_on;
    } tmr_req_t;

    function automatic pin_kind_e kind_of(input int idx);
        if (idx == PIN_PACC)      return PK_IO_PACC;
        else if (idx == PIN_CH4)  return PK_IO_CH4;
        else if (idx > PIN_CH4)   return PK_OUT_CMP;
        else                      return PK_IN_CAP;
    endfunction

    function automatic logic [PORT_W-1:0] dir_image(input logic [DIR_W-1:0] d);
        logic [PORT_W-1:0] v;
        v = '0;
        v[PIN_PACC] = d[1];
        v[PIN_CH4]  = d[0];
        return v;
    endfunction

endpackage

// File: rtl/pa_regs.sv
module pa_regs
    import pa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] latch_q,
    output logic [DIR_W-1:0]  dir_q
);

    logic hit_data;
    logic hit_dir;

    assign hit_data = wr_en && (wr_addr == ADDR_DATA);
    assign hit_dir  = wr_en && (wr_addr == ADDR_DIR);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            if (hit_data) latch_q <= wr_data;
            if (hit_dir)  dir_q   <= {wr_data[PIN_PACC], wr_data[PIN_CH4]};
        end
    end

endmodule

// File: rtl/pa_pin_cell.sv
module pa_pin_cell
    import pa_pkg::*;
#(
    parameter pin_kind_e KIND = PK_OUT_CMP
) (
    input  logic     latch_bit,
    input  logic     dir_bit,
    input  tmr_req_t req,
    input  logic     pad_in,
    output drive_t   drv,
    output logic     rd_bit
);

    always_comb begin
        drv.oe  = 1'b0;
        drv.lvl = latch_bit;
        unique case (KIND)
            PK_OUT_CMP: begin
                drv.oe = 1'b1;
                if (req.oc1_on)      drv.lvl = req.oc1_lvl;
                else if (req.ocx_on) drv.lvl = req.ocx_lvl;
            end
            PK_IO_CH4: begin
                if (req.oc1_on) begin
                    drv.oe  = 1'b1;
                    drv.lvl = req.oc1_lvl;
                end else if (req.ocx_on) begin
                    drv.oe  = 1'b1;
                    drv.lvl = req.ocx_lvl;
                end else if (req.ic_on) begin
                    drv.oe  = 1'b0;
                end else begin
                    drv.oe  = dir_bit;
                end
            end
            PK_IO_PACC: begin
                if (req.oc1_on) begin
                    drv.oe  = 1'b1;
                    drv.lvl = req.oc1_lvl;
                end else begin
                    drv.oe  = dir_bit;
                end
            end
            default: begin
                drv.oe  = 1'b0;
                drv.lvl = 1'b0;
            end
        endcase
    end

    assign rd_bit = drv.oe ? drv.lvl : pad_in;

endmodule

// File: rtl/pa_timer_port.sv
module pa_timer_port
    import pa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PORT_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    input  logic [OC1_W-1:0]  oc1_en,
    input  logic [OC1_W-1:0]  oc1_lvl,
    input  logic [OCX_W-1:0]  ocx_en,
    input  logic [OCX_W-1:0]  ocx_lvl,
    input  logic              ch4_cap,
    input  logic              ic4_en,
    input  logic              ic4_from_oc1,
    output logic [CAP_W-1:0]  cap_tap,
    output logic              pacc_tap
);

    logic [PORT_W-1:0] latch_q;
    logic [DIR_W-1:0]  dir_q;
    drive_t            drv    [PORT_W];
    logic [PORT_W-1:0] rb_vec;

    pa_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    for (genvar p = 0; p < PORT_W; p++) begin : g_pin
        if (p < SHARED_LO) begin : g_fixed_in
            assign drv[p]    = '{oe: 1'b0, lvl: 1'b0};
            assign rb_vec[p] = pin_in[p];
        end else begin : g_shared
            localparam int K = p - SHARED_LO;
            tmr_req_t req;
            logic     dir_bit;
            logic     ox_on;
            logic     ox_lvl;
            logic     ic_on;

            if (p == PIN_PACC) begin : g_pacc
                assign ox_on   = 1'b0;
                assign ox_lvl  = 1'b0;
                assign ic_on   = 1'b0;
                assign dir_bit = dir_q[1];
            end else if (p == PIN_CH4) begin : g_ch4
                assign ox_on   = ocx_en[K] & ~ch4_cap;
                assign ox_lvl  = ocx_lvl[K];
                assign ic_on   = ic4_en & ch4_cap;
                assign dir_bit = dir_q[0];
            end else begin : g_cmp
                assign ox_on   = ocx_en[K];
                assign ox_lvl  = ocx_lvl[K];
                assign ic_on   = 1'b0;
                assign dir_bit = 1'b1;
            end

            assign req = '{oc1_on: oc1_en[K], oc1_lvl: oc1_lvl[K],
                           ocx_on: ox_on, ocx_lvl: ox_lvl, ic_on: ic_on};

            pa_pin_cell #(.KIND(kind_of(p))) u_cell (
                .latch_bit (latch_q[p]),
                .dir_bit   (dir_bit),
                .req       (req),
                .pad_in    (pin_in[p]),
                .drv       (drv[p]),
                .rd_bit    (rb_vec[p])
            );
        end

        assign pin_oe[p]  = drv[p].oe;
        assign pin_out[p] = drv[p].lvl;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_DATA: rd_data = rb_vec;
            ADDR_DIR:  rd_data = dir_image(dir_q);
            default:   rd_data = '0;
        endcase
    end

    assign cap_tap[CAP_W-2:0]    = pin_in[CAP_W-2:0];
    assign cap_tap[CAP_W-1]      = ic4_from_oc1 ? oc1_lvl[0] : pin_in[PIN_CH4];
    assign pacc_tap              = pin_in[PIN_PACC];

endmodule

// File: rtl/pa_timer_port_chk.sv
module pa_timer_port_chk
    import pa_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [PORT_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [PORT_W-1:0] rd_data,
    input logic [PORT_W-1:0] pin_in,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] pin_oe,
    input logic [OC1_W-1:0]  oc1_en,
    input logic [OC1_W-1:0]  oc1_lvl,
    input logic [OCX_W-1:0]  ocx_en,
    input logic [OCX_W-1:0]  ocx_lvl,
    input logic              ch4_cap,
    input logic              ic4_en,
    input logic              ic4_from_oc1,
    input logic [CAP_W-1:0]  cap_tap,
    input logic              pacc_tap
);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && !oc1_en[4]) |-> (!pin_oe[7] && !pin_out[7]));

    a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_DIR) |=> (oc1_en[4] || pin_oe[7] == $past(wr_data[7])));

    a_r3_fixed_dirs: assert property (@(posedge clk) disable iff (rst)
        (pin_oe[6:4] == 3'b111) && (pin_oe[2:0] == 3'b000));

    a_r5_input_read: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_DATA) |-> (rd_data[2:0] == pin_in[2:0]));

    a_r6_write_reaches_pin: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_DATA) |=>
            (oc1_en[2] || ocx_en[2] || pin_out[5] == $past(wr_data[5])));

    a_r7_oc1_pin3: assert property (@(posedge clk) disable iff (rst)
        oc1_en[0] |-> (pin_oe[3] && pin_out[3] == oc1_lvl[0]));

    a_r7_oc1_pin7: assert property (@(posedge clk) disable iff (rst)
        oc1_en[4] |-> (pin_oe[7] && pin_out[7] == oc1_lvl[4]));

    a_r8_ocx_pin4: assert property (@(posedge clk) disable iff (rst)
        (!oc1_en[1] && ocx_en[1]) |-> (pin_out[4] == ocx_lvl[1]));

    a_r9_capture_input: assert property (@(posedge clk) disable iff (rst)
        (ch4_cap && ic4_en && !oc1_en[0]) |-> !pin_oe[3]);

    a_r10_cap_low: assert property (@(posedge clk) disable iff (rst)
        cap_tap[2:0] == pin_in[2:0]);

    a_r10_cap_oc1: assert property (@(posedge clk) disable iff (rst)
        ic4_from_oc1 |-> (cap_tap[3] == oc1_lvl[0]));

    a_r11_pacc: assert property (@(posedge clk) disable iff (rst)
        pacc_tap == pin_in[7]);

endmodule

bind pa_timer_port pa_timer_port_chk u_chk (.*);

// File: tb/pa_timer_port_test.sv
module pa_timer_port_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [4:0] oc1_en = '0;
    logic [4:0] oc1_lvl = '0;
    logic [3:0] ocx_en = '0;
    logic [3:0] ocx_lvl = '0;
    logic       ch4_cap = 1'b0;
    logic       ic4_en = 1'b0;
    logic       ic4_from_oc1 = 1'b0;
    logic [3:0] cap_tap;
    logic       pacc_tap;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // reference state
    logic [7:0] m_latch = '0;
    logic       m_dir7 = 1'b0;
    logic       m_dir3 = 1'b0;

    always #10 clk = ~clk;

    pa_timer_port uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .oc1_en(oc1_en), .oc1_lvl(oc1_lvl), .ocx_en(ocx_en),
        .ocx_lvl(ocx_lvl), .ch4_cap(ch4_cap), .ic4_en(ic4_en),
        .ic4_from_oc1(ic4_from_oc1), .cap_tap(cap_tap), .pacc_tap(pacc_tap)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // expected drive of one pin from model state and current inputs
    task automatic expect_pin(input int p, output logic oe, output logic lvl,
                              output string tag);
        int k;
        k = p - 3;
        if (p < 3) begin
            oe = 0; lvl = 0; tag = "R3";
        end else if (oc1_en[k]) begin
            oe = 1; lvl = oc1_lvl[k]; tag = "R7";
        end else if (p >= 4 && p <= 6 && ocx_en[k]) begin
            oe = 1; lvl = ocx_lvl[k]; tag = "R8";
        end else if (p == 3 && !ch4_cap && ocx_en[0]) begin
            oe = 1; lvl = ocx_lvl[0]; tag = "R8";
        end else if (p == 3 && ch4_cap && ic4_en) begin
            oe = 0; lvl = m_latch[3]; tag = "R9";
        end else if (p >= 4 && p <= 6) begin
            oe = 1; lvl = m_latch[p]; tag = "R6";
        end else begin
            oe = (p == 7) ? m_dir7 : m_dir3; lvl = m_latch[p]; tag = "R4";
        end
    endtask

    task automatic compare_all();
        logic [7:0] e_oe, e_out, e_rd;
        logic [3:0] e_cap;
        for (int p = 0; p < 8; p++) begin
            logic o, l;
            string t;
            expect_pin(p, o, l, t);
            e_oe[p] = o;
            e_out[p] = l;
            chk(t, $sformatf("pin%0d oe/out", p), {6'd0, pin_oe[p], pin_out[p]},
                {6'd0, o, l});
        end
        case (rd_addr)
            2'd0: begin
                for (int p = 0; p < 8; p++) e_rd[p] = e_oe[p] ? e_out[p] : pin_in[p];
                chk("R5", "data read", rd_data, e_rd);
            end
            2'd1: chk("R2", "dir read", rd_data, {m_dir7, 3'b000, m_dir3, 3'b000});
            default: chk("R2", "unmapped read", rd_data, 8'h00);
        endcase
        e_cap = {ic4_from_oc1 ? oc1_lvl[0] : pin_in[3], pin_in[2:0]};
        chk("R10", "cap_tap", {4'd0, cap_tap}, {4'd0, e_cap});
        chk("R11", "pacc_tap", {7'd0, pacc_tap}, {7'd0, pin_in[7]});
    endtask

    task automatic model_edge();
        if (rst) begin
            m_latch = '0; m_dir7 = 0; m_dir3 = 0;
        end else if (wr_en) begin
            if (wr_addr == 2'd0) m_latch = wr_data;
            else if (wr_addr == 2'd1) begin
                m_dir7 = wr_data[7]; m_dir3 = wr_data[3];
            end
        end
    endtask

    // call after inputs are set at a falling edge
    task automatic step();
        #2;
        if (!rst) compare_all();
        @(posedge clk);
        model_edge();
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; pin_in = 0;
        oc1_en = 0; oc1_lvl = 0; ocx_en = 0; ocx_lvl = 0;
        ch4_cap = 0; ic4_en = 0; ic4_from_oc1 = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; idle_inputs();
        repeat (3) begin @(posedge clk); model_edge(); end
        @(negedge clk);
        rst = 0; rd_addr = 2'd1;
        #2;
        chk("R1", "oe after reset", pin_oe, 8'h70);
        chk("R1", "out after reset", pin_out, 8'h00);
        chk("R1", "dir after reset", rd_data, 8'h00);
        @(posedge clk); model_edge();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        idle_inputs();
        wr_en = 1; wr_addr = a; wr_data = d; rd_addr = a;
        step();
    endtask

    task automatic rand_cycle(input bit timers);
        @(negedge clk);
        wr_en   = ($urandom % 3) == 0;
        wr_addr = 2'($urandom);
        wr_data = 8'($urandom);
        rd_addr = 2'($urandom);
        pin_in  = 8'($urandom);
        oc1_lvl = 5'($urandom);
        ocx_lvl = 4'($urandom);
        ic4_from_oc1 = 1'($urandom);
        if (timers) begin
            oc1_en  = 5'($urandom) & 5'($urandom);
            ocx_en  = 4'($urandom);
            ch4_cap = 1'($urandom);
            ic4_en  = 1'($urandom);
        end else begin
            oc1_en = 0; ocx_en = 0; ch4_cap = 1'($urandom); ic4_en = 0;
        end
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5a));
        do_reset();

        // R6/R3: latch drives fixed outputs, bidir pins stay off
        wr(2'd0, 8'hF8);
        wr(2'd2, 8'hFF);              // R2: unmapped write ignored
        wr(2'd3, 8'h00);              // R2: unmapped write ignored
        wr(2'd1, 8'h88);              // R4: pins 7 and 3 now drive
        @(negedge clk); idle_inputs(); rd_addr = 0; pin_in = 8'h05; step();

        // R7 with R6: write while compare 1 owns the pins, then release
        @(negedge clk); idle_inputs();
        oc1_en = 5'h1F; oc1_lvl = 5'h0A; wr_en = 1; wr_addr = 0; wr_data = 8'h00;
        step();
        @(negedge clk); wr_en = 0; step();
        @(negedge clk); oc1_en = 0; step();

        // R8 / R9 on the shared pin 3
        @(negedge clk); idle_inputs(); ocx_en = 4'hF; ocx_lvl = 4'h5; step();
        @(negedge clk); ch4_cap = 1; step();
        @(negedge clk); ic4_en = 1; pin_in = 8'h08; step();
        @(negedge clk); ch4_cap = 0; step();
        @(negedge clk); ic4_from_oc1 = 1; oc1_lvl = 5'h01; pin_in = 8'h00; step();

        // R4: direction cleared puts pins 7/3 back to input
        wr(2'd1, 8'h00);
        @(negedge clk); idle_inputs(); pin_in = 8'h88; step();

        for (int i = 0; i < 1500; i++) rand_cycle(1'b0);
        for (int i = 0; i < 2500; i++) rand_cycle(1'b1);

        do_reset();
        for (int i = 0; i < 200; i++) rand_cycle(1'b1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule